// File: doc/BRIEF.md
# Bubble-Removing Bit Sorting Network

This block cleans up the raw comparator word of a flash converter before it reaches a ROM-style encoder. Fast comparators can produce an imperfect thermometer word: stray zeros inside the run of ones, or stray ones above it. The block passes the word through a chain of compare-exchange stages. Each cell looks at two neighbouring bits and sends any one upward, toward the higher index. The result holds the same number of ones as the input, packed at the high-index end of the word, so the encoder behind it sees a single clean transition.

The stages alternate between pairing even-indexed bits with the bit above them and pairing odd-indexed bits with the bit above them. The number of stages is a parameter. When the stage count equals the word width, every input is fully sorted. With fewer stages the block corrects only bubbles that lie close to the transition, which saves logic. A register follows every group of `REG_EVERY` stages, and the final stage is always registered. A valid bit travels alongside the data, so each result appears exactly `NUM_GROUPS` clock cycles after its word is accepted, and a new word may enter on every cycle.

Top module: `bitsort_top`

## Requirements
- R1: The number of ones in every result equals the number of ones in the word that produced it.
- R2: When `NUM_STAGES` is at least `WIDTH`, every result is sorted. All ones occupy bit `WIDTH-1` down to bit `WIDTH-c`, where c is the count of ones, and every bit below that is zero.
- R3: A word that is already sorted in the form of R2, including all-zero and all-one, comes out unchanged.
- R4: With a limited depth of K stages (stage 0 pairs even bits with the bit above), a word holding a single one at bit p yields a single one at bit min(WIDTH-1, p+K) when p is even, and at min(WIDTH-1, p+K-1) when p is odd.
- R5: `outValid` is high for exactly one cycle, `NUM_GROUPS` = ceil(`NUM_STAGES`/`REG_EVERY`) cycles after each cycle in which `inValid` was high. It is never high otherwise.
- R6: `outCode` changes only in a cycle in which `outValid` is high. While no result is emitted it holds the last result, whatever `inCode` carries.
- R7: While `rstN` is low, `outValid` and `outCode` are zero.
- R8: Words presented on consecutive cycles produce results on consecutive cycles, in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | `inCode` holds a word to be sorted this cycle |
| inCode | input | WIDTH | Raw comparator word, possibly with bubbles |
| outValid | output | 1 | `outCode` holds a new result this cycle |
| outCode | output | WIDTH | Sorted word, ones packed toward the high index |

## Verification
The interesting overlap is a new word entering the first group in the same cycle that an older result leaves the last group, with every group in between also advancing. The bench provokes this with a burst of back-to-back words that is longer than the pipeline. A scoreboard queue then judges each result by its cycle stamp and its order. This shows that streaming neither drops, duplicates nor reorders words. The limited-depth variant and the hold behaviour between results are checked separately, because they depend on the stage count and on idle cycles rather than on throughput.

// File: rtl/bitsort_pkg.sv
package bitsort_pkg;

  // Upper bound on register groups; the strobe struct is sized by it.
  localparam int MAX_GROUPS = 64;

  typedef struct packed {
    logic [MAX_GROUPS-1:0] advance;  // load enable for each group register
  } sortStrobes_t;

  function automatic int numGroups(input int stages, input int every);
    return (stages + every - 1) / every;
  endfunction

endpackage

// File: rtl/bitsort_cex.sv
// One compare-exchange cell: the larger bit goes to the higher position.
module bitsort_cex (
  input  logic lowIn,
  input  logic highIn,
  output logic lowOut,
  output logic highOut
);
  assign highOut = lowIn | highIn;
  assign lowOut  = lowIn & highIn;
endmodule

// File: rtl/bitsort_stage.sv
// One transposition stage. PHASE 0 pairs (0,1),(2,3)...; PHASE 1 pairs (1,2),(3,4)...
module bitsort_stage #(
  parameter int WIDTH = 63,
  parameter int PHASE = 0
) (
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  localparam int NUM_PAIRS = (WIDTH - PHASE) / 2;
  localparam bit TOP_ALONE = ((WIDTH - PHASE) % 2) == 1;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int LO = PHASE + 2 * p;
    bitsort_cex u_cex (
      .lowIn  (dIn[LO]),
      .highIn (dIn[LO+1]),
      .lowOut (dOut[LO]),
      .highOut(dOut[LO+1])
    );
  end

  if (PHASE == 1) begin : g_bottomPass
    assign dOut[0] = dIn[0];
  end

  if (TOP_ALONE) begin : g_topPass
    assign dOut[WIDTH-1] = dIn[WIDTH-1];
  end
endmodule

// File: rtl/bitsort_datapath.sv
// Chain of stages with a register after each group and after the last stage.
module bitsort_datapath
  import bitsort_pkg::*;
#(
  parameter int WIDTH      = 63,
  parameter int NUM_STAGES = 63,
  parameter int REG_EVERY  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  sortStrobes_t       strobes,
  input  logic [WIDTH-1:0]   inCode,
  output logic [WIDTH-1:0]   outCode
);
  logic [WIDTH-1:0] stageIn  [NUM_STAGES+1];
  logic [WIDTH-1:0] cellOut  [NUM_STAGES];
  logic             unusedStrobes;

  assign unusedStrobes = ^strobes.advance;
  assign stageIn[0]    = inCode;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    bitsort_stage #(
      .WIDTH(WIDTH),
      .PHASE(s % 2)
    ) u_stage (
      .dIn (stageIn[s]),
      .dOut(cellOut[s])
    );

    if (((s + 1) % REG_EVERY == 0) || (s == NUM_STAGES - 1)) begin : g_reg
      localparam int GRP = s / REG_EVERY;
      logic [WIDTH-1:0] groupQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          groupQ <= '0;
        end else if (strobes.advance[GRP]) begin
          groupQ <= cellOut[s];
        end
      end
      assign stageIn[s+1] = groupQ;
    end else begin : g_wire
      assign stageIn[s+1] = cellOut[s];
    end
  end

  assign outCode = stageIn[NUM_STAGES];
endmodule

// File: rtl/bitsort_ctrl.sv
// Valid tracking: one flag per group register, shifted each cycle.
module bitsort_ctrl
  import bitsort_pkg::*;
#(
  parameter int NUM_GROUPS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output sortStrobes_t strobes,
  output logic         outValid
);
  logic [NUM_GROUPS-1:0] groupValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      groupValid <= '0;
    end else begin
      groupValid[0] <= inValid;
      for (int g = 1; g < NUM_GROUPS; g++) begin
        groupValid[g] <= groupValid[g-1];
      end
    end
  end

  always_comb begin
    strobes = '0;
    strobes.advance[0] = inValid;
    for (int g = 1; g < NUM_GROUPS; g++) begin
      strobes.advance[g] = groupValid[g-1];
    end
  end

  assign outValid = groupValid[NUM_GROUPS-1];
endmodule

// File: rtl/bitsort_top.sv
module bitsort_top
  import bitsort_pkg::*;
#(
  parameter int WIDTH      = 63,
  parameter int NUM_STAGES = 63,
  parameter int REG_EVERY  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inCode,
  output logic             outValid,
  output logic [WIDTH-1:0] outCode
);
  localparam int NUM_GROUPS = numGroups(NUM_STAGES, REG_EVERY);

  sortStrobes_t strobes;

  bitsort_ctrl #(
    .NUM_GROUPS(NUM_GROUPS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  bitsort_datapath #(
    .WIDTH     (WIDTH),
    .NUM_STAGES(NUM_STAGES),
    .REG_EVERY (REG_EVERY)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .inCode (inCode),
    .outCode(outCode)
  );
endmodule

// File: rtl/bitsort_checker.sv
module bitsort_checker
  import bitsort_pkg::*;
#(
  parameter int WIDTH      = 63,
  parameter int NUM_STAGES = 63,
  parameter int REG_EVERY  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [WIDTH-1:0] inCode,
  input logic             outValid,
  input logic [WIDTH-1:0] outCode
);
  localparam int NUM_GROUPS = numGroups(NUM_STAGES, REG_EVERY);

  logic [7:0]       inFlight;
  logic [WIDTH-1:0] invCode;
  logic [WIDTH-1:0] invCodeInc;
  logic             unusedIn;

  assign unusedIn   = ^inCode;
  assign invCode    = ~outCode;
  assign invCodeInc = invCode + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= '0;
    end else begin
      inFlight <= inFlight + {7'd0, inValid} - {7'd0, outValid};
    end
  end

  initial begin
    a_r5_group_limit: assert (NUM_GROUPS <= MAX_GROUPS && NUM_GROUPS < 200);
  end

  // R5: never more words inside than group registers
  a_r5_inflight_bound: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 8'(NUM_GROUPS));

  // R5: a result is only emitted for an accepted word
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inFlight != 8'd0);

  // R6: the output word moves only together with outValid
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outCode != $past(outCode)) |-> outValid);

  // R7: reset clears the output side
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!outValid && outCode == '0));

  if (NUM_STAGES >= WIDTH) begin : g_fullDepth
    // R2: ones packed at the top, i.e. inverted word is a run of low ones
    a_r2_sorted: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> ((invCode & invCodeInc) == '0));
  end
endmodule

bind bitsort_top bitsort_checker #(
  .WIDTH     (WIDTH),
  .NUM_STAGES(NUM_STAGES),
  .REG_EVERY (REG_EVERY)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inCode  (inCode),
  .outValid(outValid),
  .outCode (outCode)
);

// File: tb/tb_bitsort_top.sv
module tb_bitsort_top;
  localparam int W        = 63;
  localparam int STAGES   = 63;
  localparam int EVERY    = 8;
  localparam int GROUPS   = (STAGES + EVERY - 1) / EVERY;
  localparam int SW       = 16;
  localparam int SSTAGES  = 3;
  localparam int SEVERY   = 2;

  typedef struct {
    logic [W-1:0] din;
    logic [W-1:0] exp;
    int           stamp;
    string        tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [W-1:0]  inCode = '0;
  logic          outValid;
  logic [W-1:0]  outCode;
  logic          sValid = 1'b0;
  logic [SW-1:0] sCode = '0;
  logic          sOutValid;
  logic [SW-1:0] sOutCode;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 1'b0;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitsort_top #(.WIDTH(W), .NUM_STAGES(STAGES), .REG_EVERY(EVERY)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCode(inCode),
    .outValid(outValid), .outCode(outCode));

  bitsort_top #(.WIDTH(SW), .NUM_STAGES(SSTAGES), .REG_EVERY(SEVERY)) dutShallow (
    .clk(clk), .rstN(rstN), .inValid(sValid), .inCode(sCode),
    .outValid(sOutValid), .outCode(sOutCode));

  function automatic logic [W-1:0] packTop(input int c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i >= W - c);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] v, input string tag);
    item_t it;
    @(negedge clk);
    inValid = 1'b1;
    inCode  = v;
    it.din = v; it.exp = packTop($countones(v)); it.stamp = cyc; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: compare each emitted result with the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5 unexpected result", outCode, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(outCode == it.exp, {it.tag, " R2 sorted value"}, outCode, it.exp);
        check($countones(outCode) == $countones(it.din), {it.tag, " R1 ones count"},
              W'($countones(outCode)), W'($countones(it.din)));
        check(cyc == it.stamp + GROUPS, {it.tag, " R5/R8 latency and order"},
              W'(cyc), W'(it.stamp + GROUPS));
      end
    end
  end

  // R4: lone one through the 3-stage, 16-bit variant
  task automatic shallowLone(input int p);
    int expPos;
    logic [SW-1:0] expV;
    expPos = (p % 2 == 0) ? p + SSTAGES : p + SSTAGES - 1;
    if (expPos > SW - 1) expPos = SW - 1;
    expV = '0; expV[expPos] = 1'b1;
    @(negedge clk);
    sValid = 1'b1;
    sCode = '0; sCode[p] = 1'b1;
    @(negedge clk);
    sValid = 1'b0;
    @(negedge clk);
    check(sOutValid && sOutCode == expV, "R4 limited depth lone one",
          W'({sOutValid, sOutCode}), W'({1'b1, expV}));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] v;
    logic [W-1:0] held;
    logic [W-1:0] lfsr;
    repeat (3) @(negedge clk);
    check(!outValid && outCode == '0, "R7 reset state", {outValid, outCode[W-2:0]}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: already sorted words pass unchanged
    send(packTop(0), "R3 all zero");
    send(packTop(W), "R3 all one");
    send(packTop(1), "R3 one at top");
    send(packTop(20), "R3 twenty");
    drain();

    // Bubbles near and far from the transition
    v = packTop(30); v[40] = 1'b0; v[5] = 1'b1;
    send(v, "R2 near bubbles");
    v = '0; for (int i = 0; i < 10; i++) v[i] = 1'b1;
    send(v, "R2 reversed run");
    v = '0; for (int i = 0; i < W; i += 2) v[i] = 1'b1;
    send(v, "R2 alternating");
    v = '0; v[0] = 1'b1;
    send(v, "R2 lone bottom one");
    v = packTop(W); v[W-1] = 1'b0;
    send(v, "R2 zero at top");
    drain();

    // R8: long burst, entries and exits share cycles
    lfsr = 63'h1ACE_5EED_1234_0F0F;
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[W-2:0], lfsr[W-1] ^ lfsr[W-2]};
      send(lfsr, "R8 burst");
    end
    drain();

    // R6: hold while idle with changing input data
    held = outCode;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      inCode = {W{k[0]}};
      check(!outValid && outCode == held, "R6 hold when idle", outCode, held);
    end

    // R4: limited depth variant
    shallowLone(0);
    shallowLone(4);
    shallowLone(5);
    shallowLone(14);
    shallowLone(15);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule